// File: doc/BRIEF.md
# Timer Channel Status Flag Register

This block keeps the three event flags for one channel of a 16-bit timer: one for counter wrap in either direction, and one for each of the two general registers, A and B. Each general-register flag takes its set event from one of two sources. A compare-equal pulse sets it when that register is in compare mode. A capture pulse sets it when that register is in capture mode. The counter, the capture-pin edge logic and the interrupt controller are outside this block. It only receives their single-cycle event pulses.

Software sees the flags through an 8-bit read port. It clears a flag with a two-step handshake. First, a read strobe arms every flag that is 1 at that moment. Later, a write with a 0 in an armed flag's bit clears that flag. Writing a 1 never changes a flag. Writing a 0 to a flag that has not been armed also does nothing. A set event always beats a clearing write in the same cycle and disarms the flag, so a new event is never lost. One interrupt request per flag follows the flag value, gated by its own enable input.

Top module: `tsf_status_reg`

## Requirements
- R1: `cpu_rdata` shows the register at all times. Bit 0 is flag A, bit 1 is flag B and bit 2 is the wrap flag. Bits 7 to 3 always read 1.
- R2: While `rst_n` is low, all flags and arm bits are 0, so `cpu_rdata` reads 8'hF8 and `irq` reads 0.
- R3: A pulse on `cnt_ovf` (up-count wrap) or on `cnt_unf` (down-count wrap) sets the wrap flag (bit 2), visible after the next rising edge.
- R4: While `mode_cap[i]` is 0 (compare mode), `cmp_eq[i]` sets match flag i (index 0 is A, index 1 is B). `cap_evt[i]` has no effect.
- R5: While `mode_cap[i]` is 1 (capture mode), `cap_evt[i]` sets match flag i. `cmp_eq[i]` has no effect.
- R6: A cycle with `cpu_sel` and `cpu_rd` both high arms every flag that is 1 in that cycle. A later cycle with `cpu_sel` and `cpu_wr` high and a 0 in an armed flag's bit of `cpu_wdata` clears that flag and its arm bit. The arm bit stays set across unrelated writes. A 0 written to an unarmed flag leaves it unchanged.
- R7: Writing a 1 to a flag bit neither sets nor clears that flag.
- R8: If a set event and a clearing write hit the same flag in the same cycle, the flag stays 1 and is disarmed. A following 0-write without a fresh read then leaves it set.
- R9: `irq[i]` equals flag i ANDed with `irq_en[i]`, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_ovf | input | 1 | Counter wrapped upward, one-cycle pulse |
| cnt_unf | input | 1 | Counter wrapped downward, one-cycle pulse |
| cmp_eq | input | 2 | Counter equals general register [B,A] |
| cap_evt | input | 2 | Capture loaded general register [B,A] |
| mode_cap | input | 2 | 1 = capture mode, 0 = compare mode, per register [B,A] |
| cpu_sel | input | 1 | Register select |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Register read value |
| irq_en | input | 3 | Per-flag interrupt enable [wrap,B,A] |
| irq | output | 3 | Per-flag interrupt request [wrap,B,A] |

## Verification
The set logic is driven with compare pulses in capture mode and capture pulses in compare mode. It is then driven with each pulse in its matching mode. Together these show that the mode select routes the right source to each register's flag and blocks the other. Wrap pulses in both directions show that both feed the same flag. The clear handshake is driven with several patterns that show arming, not the written value alone, decides a clear: a write of zeros before any read, writes of ones to armed flags, partial clears that leave other armed flags for later writes, and a set event that collides with a clearing write.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    // Per-flag stored state: the visible flag and its clear-permission bit.
    typedef struct packed {
        logic flag;
        logic armed;
    } tsf_cell_t;

endpackage

// File: rtl/tsf_set_logic.sv
module tsf_set_logic #(
    parameter int NUM_MATCH = 2
) (
    input  logic                 cnt_ovf,
    input  logic                 cnt_unf,
    input  logic [NUM_MATCH-1:0] cmp_eq,
    input  logic [NUM_MATCH-1:0] cap_evt,
    input  logic [NUM_MATCH-1:0] mode_cap,
    output logic [NUM_MATCH:0]   set_evt
);

    // Match flags sit in the low bits; the wrap flag sits just above them.
    for (genvar gi = 0; gi < NUM_MATCH; gi++) begin : g_match
        always_comb begin
            set_evt[gi] = mode_cap[gi] ? cap_evt[gi] : cmp_eq[gi];
        end
    end

    always_comb begin
        set_evt[NUM_MATCH] = cnt_ovf | cnt_unf;
    end

endmodule

// File: rtl/tsf_flag_cell.sv
module tsf_flag_cell
    import tsf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_arm,
    input  logic wr_zero,
    output logic flag
);

    tsf_cell_t cell_d;
    tsf_cell_t cell_q;
    logic      clr_ok;

    always_comb begin
        cell_d = cell_q;
        clr_ok = wr_zero & cell_q.armed;
        if (set_evt) begin
            // A new event wins and withdraws any earlier clear permission.
            cell_d.flag  = 1'b1;
            cell_d.armed = 1'b0;
        end else if (clr_ok) begin
            cell_d.flag  = 1'b0;
            cell_d.armed = 1'b0;
        end else if (rd_arm && cell_q.flag) begin
            cell_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign flag = cell_q.flag;

endmodule

// File: rtl/tsf_read_port.sv
module tsf_read_port #(
    parameter int REG_W     = 8,
    parameter int NUM_FLAGS = 3
) (
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [REG_W-1:0]     rdata
);

    localparam int PAD_W = REG_W - NUM_FLAGS;

    always_comb begin
        rdata = {{PAD_W{1'b1}}, flags};
    end

endmodule

// File: rtl/tsf_status_reg.sv
module tsf_status_reg #(
    parameter int REG_W     = 8,
    parameter int NUM_MATCH = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cnt_ovf,
    input  logic                   cnt_unf,
    input  logic [NUM_MATCH-1:0]   cmp_eq,
    input  logic [NUM_MATCH-1:0]   cap_evt,
    input  logic [NUM_MATCH-1:0]   mode_cap,
    input  logic                   cpu_sel,
    input  logic                   cpu_rd,
    input  logic                   cpu_wr,
    input  logic [REG_W-1:0]       cpu_wdata,
    output logic [REG_W-1:0]       cpu_rdata,
    input  logic [NUM_MATCH:0]     irq_en,
    output logic [NUM_MATCH:0]     irq
);

    localparam int NUM_FLAGS = NUM_MATCH + 1;

    logic [NUM_FLAGS-1:0] set_evt;
    logic [NUM_FLAGS-1:0] flags;
    logic                 rd_arm;
    logic                 wr_hit;
    logic                 wdata_hi_unused;

    assign rd_arm          = cpu_sel & cpu_rd;
    assign wr_hit          = cpu_sel & cpu_wr;
    assign wdata_hi_unused = ^cpu_wdata[REG_W-1:NUM_FLAGS];

    tsf_set_logic #(
        .NUM_MATCH (NUM_MATCH)
    ) u_set (
        .cnt_ovf  (cnt_ovf),
        .cnt_unf  (cnt_unf),
        .cmp_eq   (cmp_eq),
        .cap_evt  (cap_evt),
        .mode_cap (mode_cap),
        .set_evt  (set_evt)
    );

    for (genvar gf = 0; gf < NUM_FLAGS; gf++) begin : g_cell
        tsf_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_evt[gf]),
            .rd_arm  (rd_arm),
            .wr_zero (wr_hit & ~cpu_wdata[gf]),
            .flag    (flags[gf])
        );
    end

    tsf_read_port #(
        .REG_W     (REG_W),
        .NUM_FLAGS (NUM_FLAGS)
    ) u_rd (
        .flags (flags),
        .rdata (cpu_rdata)
    );

    assign irq = flags & irq_en;

endmodule

// File: rtl/tsf_status_chk.sv
module tsf_status_chk #(
    parameter int REG_W     = 8,
    parameter int NUM_MATCH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cnt_ovf,
    input logic                 cnt_unf,
    input logic [NUM_MATCH-1:0] cmp_eq,
    input logic [NUM_MATCH-1:0] cap_evt,
    input logic [NUM_MATCH-1:0] mode_cap,
    input logic                 cpu_sel,
    input logic                 cpu_wr,
    input logic [REG_W-1:0]     cpu_wdata,
    input logic [REG_W-1:0]     cpu_rdata,
    input logic [NUM_MATCH:0]   irq_en,
    input logic [NUM_MATCH:0]   irq
);

    localparam int NUM_FLAGS = NUM_MATCH + 1;

    AST_PAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        &cpu_rdata[REG_W-1:NUM_FLAGS]); // R1

    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_ovf || cnt_unf) |=> cpu_rdata[NUM_MATCH]); // R3

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (cpu_rdata[NUM_MATCH:0] & irq_en)); // R9

    for (genvar gi = 0; gi < NUM_MATCH; gi++) begin : g_chk
        AST_CMP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_cap[gi] && cmp_eq[gi]) |=> cpu_rdata[gi]); // R4

        AST_CAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_cap[gi] && cap_evt[gi]) |=> cpu_rdata[gi]); // R5

        AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cpu_rdata[gi]) |->
                $past(mode_cap[gi] ? cap_evt[gi] : cmp_eq[gi])); // R7
    end

    for (genvar gf = 0; gf < NUM_FLAGS; gf++) begin : g_clr
        AST_FALL_NEEDS_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cpu_rdata[gf]) |-> $past(cpu_sel && cpu_wr && !cpu_wdata[gf])); // R6
    end

endmodule

bind tsf_status_reg tsf_status_chk #(
    .REG_W     (REG_W),
    .NUM_MATCH (NUM_MATCH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_ovf   (cnt_ovf),
    .cnt_unf   (cnt_unf),
    .cmp_eq    (cmp_eq),
    .cap_evt   (cap_evt),
    .mode_cap  (mode_cap),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .irq_en    (irq_en),
    .irq       (irq)
);

// File: tb/tb_tsf_status_reg.sv
`timescale 1ns/1ps
module tb_tsf_status_reg;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cnt_ovf, cnt_unf;
    logic [1:0] cmp_eq, cap_evt, mode_cap;
    logic       cpu_sel, cpu_rd, cpu_wr;
    logic [7:0] cpu_wdata, cpu_rdata;
    logic [2:0] irq_en, irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    tsf_status_reg dut (
        .clk(clk), .rst_n(rst_n), .cnt_ovf(cnt_ovf), .cnt_unf(cnt_unf),
        .cmp_eq(cmp_eq), .cap_evt(cap_evt), .mode_cap(mode_cap),
        .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq_en(irq_en), .irq(irq)
    );

    // ovf, unf, cmp[B,A], cap[B,A], mode[B,A], rd, wr, wd[wrap,B,A], exp[wrap,B,A], req
    typedef struct packed {
        logic       ovf;
        logic       unf;
        logic [1:0] cmp;
        logic [1:0] cap;
        logic [1:0] mode;
        logic       rd;
        logic       wr;
        logic [2:0] wd;
        logic [2:0] exp;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,2'b11,2'b00,2'b11,1'b0,1'b0,3'b111,3'b000,4'd5}, // R5 compare ignored in capture
        '{1'b0,1'b0,2'b00,2'b11,2'b00,1'b0,1'b0,3'b111,3'b000,4'd4}, // R4 capture ignored in compare
        '{1'b0,1'b0,2'b01,2'b00,2'b00,1'b0,1'b0,3'b111,3'b001,4'd4}, // R4 compare sets A
        '{1'b0,1'b0,2'b00,2'b10,2'b10,1'b0,1'b0,3'b111,3'b011,4'd5}, // R5 capture sets B
        '{1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b1,3'b000,3'b011,4'd6}, // R6 zero write unread
        '{1'b1,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0,3'b111,3'b111,4'd3}, // R3 up wrap
        '{1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b1,3'b111,3'b111,4'd7}, // R7 ones written
        '{1'b0,1'b0,2'b00,2'b00,2'b00,1'b1,1'b0,3'b111,3'b111,4'd6}, // R6 read arms all
        '{1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b1,3'b110,3'b110,4'd6}, // R6 clear A only
        '{1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b1,3'b011,3'b010,4'd6}, // R6 clear wrap only
        '{1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b1,3'b000,3'b000,4'd6}, // R6 B still armed
        '{1'b0,1'b1,2'b00,2'b00,2'b00,1'b0,1'b0,3'b111,3'b100,4'd3}, // R3 down wrap
        '{1'b0,1'b0,2'b00,2'b00,2'b00,1'b1,1'b0,3'b111,3'b100,4'd6}, // R6 arm wrap
        '{1'b0,1'b1,2'b00,2'b00,2'b00,1'b0,1'b1,3'b000,3'b100,4'd8}, // R8 set beats clear
        '{1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b1,3'b000,3'b100,4'd8}, // R8 disarmed by set
        '{1'b0,1'b0,2'b00,2'b00,2'b00,1'b1,1'b0,3'b111,3'b100,4'd6}, // R6 re-arm
        '{1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b1,3'b111,3'b100,4'd7}, // R7 one on armed flag
        '{1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b1,3'b000,3'b000,4'd6}, // R6 armed clear
        '{1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b1,3'b111,3'b000,4'd7}  // R7 one never sets
    };

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic idle();
        cnt_ovf = 0; cnt_unf = 0; cmp_eq = 0; cap_evt = 0;
        cpu_sel = 0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = 8'hFF;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; idle(); mode_cap = 0; irq_en = 3'b111;
        repeat (3) @(posedge clk);
        #1;
        chk("R2 reset rdata", cpu_rdata, 8'hF8);
        chk("R2 reset irq", {5'd0, irq}, 8'h00);
        @(negedge clk); rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cnt_ovf = VECS[i].ovf; cnt_unf = VECS[i].unf;
            cmp_eq = VECS[i].cmp; cap_evt = VECS[i].cap; mode_cap = VECS[i].mode;
            cpu_sel = VECS[i].rd | VECS[i].wr;
            cpu_rd = VECS[i].rd; cpu_wr = VECS[i].wr;
            cpu_wdata = {5'b11111, VECS[i].wd};
            @(posedge clk); #1;
            chk($sformatf("R%0d vec %0d rdata (R1 layout)", VECS[i].rq, i),
                cpu_rdata, {5'b11111, VECS[i].exp});
            chk($sformatf("R9 vec %0d irq", i), {5'd0, irq}, {5'd0, VECS[i].exp});
        end

        // R9: enable gating per flag
        @(negedge clk); idle(); irq_en = 3'b010; mode_cap = 2'b00; cmp_eq = 2'b11;
        @(posedge clk); #1;
        chk("R9 gated irq", {5'd0, irq}, 8'h02);
        chk("R4 both compare", cpu_rdata, 8'hFB);

        // R1: writes to pad bits with zeros do not change read-back of pad bits
        @(negedge clk); idle(); cpu_sel = 1; cpu_wr = 1; cpu_wdata = 8'h07;
        @(posedge clk); #1;
        chk("R1 pad bits stay one", cpu_rdata, 8'hFB);

        // R2: reset mid-operation clears flags
        @(negedge clk); idle(); rst_n = 0;
        @(posedge clk); #1;
        chk("R2 mid reset", cpu_rdata, 8'hF8);
        chk("R2 mid reset irq", {5'd0, irq}, 8'h00);
        @(negedge clk); rst_n = 1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule